// File: doc/BRIEF.md
# Strobed overvoltage fault filter

This block cleans up the output of an overvoltage comparator in a switching converter controller. The comparator watches a scaled copy of the output voltage, which is only meaningful while the power switch is off. The filter therefore ignores the comparator during the on-time. After each turn-off it waits a fixed strobe delay so that switching ringing has settled, and then looks at the flag inside a short sampling window. Each off-time gives at most one sample.

A sample that finds the flag high counts as one overvoltage cycle. An oscillator cycle that ends without any such sample clears the run. When the run reaches the limit, which is four by default, the block latches a fault. While the fault is latched the gate drive is forced low, and a one-cycle restart request pulse is issued. The fault stays latched until the supply supervisor sends a clear.

Top module: `ovp_strobe_filter`

## Requirements
- R1: After reset, `fault_o` and `restart_req_o` are 0 and `gate_o` equals `gate_on_i`. Before the first turn-off no sample is taken.
- R2: A high flag while `gate_on_i` is 1 is never sampled. An oscillator cycle whose only high flag falls in the on-time counts as a clean cycle.
- R3: Number the clock edges that see `gate_on_i` low after a turn-off as 1, 2, and so on. A high flag at edges 1 to STROBE_CYC is ignored.
- R4: A high flag at edges later than STROBE_CYC+WINDOW_CYC in the same off-time is ignored.
- R5: A high flag at any edge from STROBE_CYC+1 to STROBE_CYC+WINDOW_CYC adds one to the run. It adds exactly one per off-time, however many edges in the window see the flag high.
- R6: If the switch turns on again before the strobe delay has ended, that off-time gives no sample.
- R7: When `osc_tick_i` marks the start of a new oscillator cycle and the previous cycle had no counted sample, the run returns to zero.
- R8: `fault_o` rises at the clock edge that counts the RUN_LIMIT-th consecutive overvoltage cycle, and not before.
- R9: While `fault_o` is 1, `gate_o` is 0. `restart_req_o` is high for exactly one clock cycle each time a fault is entered.
- R10: `fault_o` stays 1 until `fault_clr_i` is sampled high. A clear takes priority over a fault being set, sets `fault_o` to 0 and also zeroes the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_on_i | input | 1 | Gate request from the PWM logic; 1 means the switch is on |
| osc_tick_i | input | 1 | One-clock pulse at the start of each oscillator cycle |
| ovp_flag_i | input | 1 | Raw output of the overvoltage comparator |
| fault_clr_i | input | 1 | Fault clear from the supply supervisor |
| gate_o | output | 1 | Gate drive; the gate request masked by the fault |
| fault_o | output | 1 | Latched overvoltage fault |
| restart_req_o | output | 1 | One-cycle auto-restart request when a fault is entered |

## Verification
A flag value that is driven before edge number j of an off-time is judged at that edge. It counts only when j lies between STROBE_CYC+1 and STROBE_CYC+WINDOW_CYC. The bench builds its flag patterns from that edge number, so the ignored patterns end exactly one edge before the window or start exactly one edge after it. `fault_o` and `restart_req_o` change at the edge that counts the fourth sample. `gate_o` follows the fault in the same cycle. The bench reads the outputs only at falling edges after the oscillator cycle concerned has finished. The restart pulse is counted at every falling edge, so a pulse that is too long or missing shows up in the count.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  // Defaults for a 50 MHz clock: 2.2 us strobe delay, 200 ns window.
  localparam int unsigned DEF_STROBE_CYC = 110;
  localparam int unsigned DEF_WINDOW_CYC = 10;
  localparam int unsigned DEF_RUN_LIMIT  = 4;
endpackage

// File: rtl/ovp_strobe_sampler.sv
module ovp_strobe_sampler #(
  parameter int unsigned STROBE_CYC = ovp_pkg::DEF_STROBE_CYC,
  parameter int unsigned WINDOW_CYC = ovp_pkg::DEF_WINDOW_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_on_i,
  input  logic ovp_flag_i,
  output logic sample_o
);
  localparam int unsigned OFF_MAX = STROBE_CYC + WINDOW_CYC;
  localparam int unsigned CNT_W   = $clog2(OFF_MAX + 1);

  logic [CNT_W-1:0] off_cnt;
  logic             taken;
  logic             in_win;

  assign in_win   = (off_cnt >= CNT_W'(STROBE_CYC)) && (off_cnt < CNT_W'(OFF_MAX));
  assign sample_o = in_win && !gate_on_i && ovp_flag_i && !taken;

  // Saturated at reset so nothing is sampled before a real turn-off.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt <= CNT_W'(OFF_MAX);
      taken   <= 1'b1;
    end else if (gate_on_i) begin
      off_cnt <= '0;
      taken   <= 1'b0;
    end else begin
      if (off_cnt != CNT_W'(OFF_MAX)) off_cnt <= off_cnt + 1'b1;
      if (sample_o) taken <= 1'b1;
    end
  end
endmodule

// File: rtl/ovp_run_counter.sv
module ovp_run_counter #(
  parameter int unsigned RUN_LIMIT = ovp_pkg::DEF_RUN_LIMIT
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sample_i,
  input  logic                         tick_i,
  input  logic                         clr_i,
  output logic [$clog2(RUN_LIMIT+1)-1:0] run_cnt_o,
  output logic                         cycle_hit_o,
  output logic                         limit_o
);
  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1);

  logic [RUN_W-1:0] base;
  logic [RUN_W-1:0] nxt;

  // A tick closes the previous cycle; a clean cycle drops the run.
  assign base    = (tick_i && !cycle_hit_o) ? '0 : run_cnt_o;
  assign limit_o = sample_i && (base == RUN_W'(RUN_LIMIT - 1));

  always_comb begin
    nxt = base;
    if (sample_i && base != RUN_W'(RUN_LIMIT)) nxt = base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_o   <= '0;
      cycle_hit_o <= 1'b0;
    end else if (clr_i) begin
      run_cnt_o   <= '0;
      cycle_hit_o <= 1'b0;
    end else begin
      run_cnt_o   <= nxt;
      cycle_hit_o <= tick_i ? sample_i : (cycle_hit_o || sample_i);
    end
  end
endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o,
  output logic enter_o
);
  logic fault_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      fault_d <= 1'b0;
    end else begin
      fault_d <= fault_o;
      if (clr_i)      fault_o <= 1'b0;
      else if (set_i) fault_o <= 1'b1;
    end
  end

  assign enter_o = fault_o && !fault_d;
endmodule

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter #(
  parameter int unsigned STROBE_CYC = ovp_pkg::DEF_STROBE_CYC,
  parameter int unsigned WINDOW_CYC = ovp_pkg::DEF_WINDOW_CYC,
  parameter int unsigned RUN_LIMIT  = ovp_pkg::DEF_RUN_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_on_i,
  input  logic osc_tick_i,
  input  logic ovp_flag_i,
  input  logic fault_clr_i,
  output logic gate_o,
  output logic fault_o,
  output logic restart_req_o
);
  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1);

  logic             sample;
  logic [RUN_W-1:0] run_cnt;
  logic             cycle_hit;
  logic             limit;

  ovp_strobe_sampler #(
    .STROBE_CYC(STROBE_CYC),
    .WINDOW_CYC(WINDOW_CYC)
  ) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_on_i  (gate_on_i),
    .ovp_flag_i (ovp_flag_i),
    .sample_o   (sample)
  );

  ovp_run_counter #(
    .RUN_LIMIT(RUN_LIMIT)
  ) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample),
    .tick_i      (osc_tick_i),
    .clr_i       (fault_clr_i),
    .run_cnt_o   (run_cnt),
    .cycle_hit_o (cycle_hit),
    .limit_o     (limit)
  );

  ovp_fault_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (limit),
    .clr_i   (fault_clr_i),
    .fault_o (fault_o),
    .enter_o (restart_req_o)
  );

  assign gate_o = gate_on_i && !fault_o;
endmodule

// File: rtl/ovp_strobe_filter_chk.sv
module ovp_strobe_filter_chk #(
  parameter int unsigned RUN_LIMIT = 4,
  parameter int unsigned RUN_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_on_i,
  input logic             osc_tick_i,
  input logic             fault_clr_i,
  input logic             gate_o,
  input logic             fault_o,
  input logic             restart_req_o,
  input logic             sample,
  input logic [RUN_W-1:0] run_cnt,
  input logic             cycle_hit
);
  p_no_sample_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on_i |-> !sample);

  p_clean_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_tick_i && !cycle_hit && !sample) |=> (run_cnt == '0));

  p_run_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= RUN_W'(RUN_LIMIT));

  p_fault_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && !fault_clr_i && sample && run_cnt == RUN_W'(RUN_LIMIT - 1) && !osc_tick_i)
    |=> fault_o);

  p_gate_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !gate_o);

  p_restart_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_req_o |=> !restart_req_o);

  p_fault_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

  p_fault_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_clr_i |=> (!fault_o && run_cnt == '0));
endmodule

bind ovp_strobe_filter ovp_strobe_filter_chk #(
  .RUN_LIMIT(RUN_LIMIT),
  .RUN_W    (RUN_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .gate_on_i     (gate_on_i),
  .osc_tick_i    (osc_tick_i),
  .fault_clr_i   (fault_clr_i),
  .gate_o        (gate_o),
  .fault_o       (fault_o),
  .restart_req_o (restart_req_o),
  .sample        (sample),
  .run_cnt       (run_cnt),
  .cycle_hit     (cycle_hit)
);

// File: tb/ovp_strobe_filter_bench.sv
module ovp_strobe_filter_bench;
  localparam int DLY   = ovp_pkg::DEF_STROBE_CYC;
  localparam int WIN   = ovp_pkg::DEF_WINDOW_CYC;
  localparam int LIM   = ovp_pkg::DEF_RUN_LIMIT;
  localparam int ON_L  = 40;
  localparam int OFF_L = DLY + WIN + 30;

  typedef enum int {M_CLEAN, M_HOT, M_EARLY, M_LATE, M_INWIN, M_ONFLAG, M_SHORT} mode_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_on = 1'b0, tick = 1'b0, flag = 1'b0, clr = 1'b0;
  logic gate_w, fault_w, rr_w;
  int n_chk = 0, n_bad = 0, n_pulse = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ovp_strobe_filter u_ovp_strobe_filter (
    .clk_i(clk), .rst_ni(rst_n), .gate_on_i(gate_on), .osc_tick_i(tick),
    .ovp_flag_i(flag), .fault_clr_i(clr), .gate_o(gate_w), .fault_o(fault_w),
    .restart_req_o(rr_w)
  );

  always @(negedge clk) if (rr_w) n_pulse++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One oscillator cycle; edge j of the off-time sees the flag driven at t = ON_L+j-1.
  task automatic osc_cycle(input mode_t m);
    int off_len;
    off_len = (m == M_SHORT) ? DLY / 2 : OFF_L;
    for (int t = 0; t < ON_L + off_len; t++) begin
      int j;
      @(negedge clk);
      j = t - ON_L + 1;
      tick = (t == 0);
      gate_on = (t < ON_L);
      case (m)
        M_HOT:    flag = (j >= 1);
        M_SHORT:  flag = (j >= 1);
        M_EARLY:  flag = (j >= 1) && (j <= DLY);
        M_LATE:   flag = (j > DLY + WIN);
        M_INWIN:  flag = (j > DLY) && (j <= DLY + WIN);
        M_ONFLAG: flag = (t < ON_L);
        default:  flag = 1'b0;
      endcase
    end
    @(negedge clk);
    tick = 1'b0;
    flag = 1'b0;
  endtask

  task automatic clear_fault();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 fault after reset", fault_w, 0);
    check("R1 restart after reset", rr_w, 0);
    gate_on = 1'b1;
    #1;
    check("R1 gate follows request", gate_w, 1);
    gate_on = 1'b0;
    flag = 1'b1;
    repeat (DLY + WIN + 5) @(negedge clk);
    flag = 1'b0;
    check("R1 no sample before first turn-off", fault_w, 0);
  endtask

  task automatic t_fault_entry();
    int p0;
    p0 = n_pulse;
    repeat (LIM - 1) osc_cycle(M_HOT);
    check("R5 one sample per off-time, no fault yet", fault_w, 0);
    osc_cycle(M_HOT);
    check("R8 fault on fourth hot cycle", fault_w, 1);
    check("R9 single restart pulse", n_pulse - p0, 1);
    check("R9 restart low after pulse", rr_w, 0);
    @(negedge clk);
    gate_on = 1'b1;
    #1;
    check("R9 gate forced low in fault", gate_w, 0);
    gate_on = 1'b0;
    osc_cycle(M_CLEAN);
    osc_cycle(M_CLEAN);
    check("R10 fault held over clean cycles", fault_w, 1);
    clear_fault();
    check("R10 fault cleared", fault_w, 0);
    repeat (LIM - 1) osc_cycle(M_HOT);
    check("R10 clear zeroed the run", fault_w, 0);
    clear_fault();
  endtask

  task automatic t_ignored(input mode_t m, input string req);
    clear_fault();
    repeat (LIM - 1) osc_cycle(M_HOT);
    osc_cycle(m);
    osc_cycle(M_HOT);
    check(req, fault_w, 0);
  endtask

  task automatic t_clean_breaks_run();
    clear_fault();
    repeat (LIM - 1) osc_cycle(M_HOT);
    osc_cycle(M_CLEAN);
    repeat (LIM - 1) osc_cycle(M_HOT);
    check("R7 clean cycle breaks run", fault_w, 0);
    osc_cycle(M_HOT);
    check("R7 run counts again after clear", fault_w, 1);
  endtask

  task automatic t_window_only();
    clear_fault();
    repeat (LIM) osc_cycle(M_INWIN);
    check("R5 flag only inside window counts", fault_w, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fault_entry();
    t_ignored(M_ONFLAG, "R2 on-time flag ignored");
    t_ignored(M_EARLY,  "R3 flag before strobe ignored");
    t_ignored(M_LATE,   "R4 flag after window ignored");
    t_ignored(M_SHORT,  "R6 short off-time not sampled");
    t_clean_breaks_run();
    t_window_only();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule